// File: doc/BRIEF.md
# Programmable Uncore Event Counter

This block is a small bank of programmable counters that count events from a cache and uncore subsystem. Each cycle, the block receives three kinds of input. The first is a set of cache lookups, each tagged with the line state it found and the kind of request that made it. The second is a set of snoop responses, each tagged with a response type and the source that caused the snoop. The third is two tracker-queue occupancy counts.

Each counter has its own control word. The control word selects one event and a unit mask that filters the tagged inputs. The resulting per-cycle count then passes through a threshold compare, an optional inversion and an optional edge detector before it reaches the counter.

Software programs the block through a flat register port. A write strobe, an address and data load either a control word or a counter value. A combinational read port returns either one at any address. The counters never raise interrupts and never chain into each other.

Top module: `uec_top`

## Requirements
- R1: Raw sum mode. With a zero threshold and edge detect off, an enabled counter adds the whole per-cycle event count, which may exceed one, at the next clock edge.
- R2: Threshold mode. With a nonzero threshold and invert off, the counter adds one in each cycle whose event count is greater than or equal to the threshold, and nothing in other cycles.
- R3: Inverted threshold. With a nonzero threshold and invert on, the counter adds one in each cycle whose event count is strictly below the threshold.
- R4: Edge detect. With edge detect on, the counter adds one only in a cycle where the qualified condition is true and was false in the previous enabled cycle.
- R5: Lookup event (code 0x34). A valid lookup counts only if both of these unit-mask bits are set:
  - bit {0,state}, where the state is 2 bits with M=0, E=1, S=2, I=3;
  - bit {1,req}, where the request is 2 bits with core read=0, core write=1, external snoop=2, other queue=3.
- R6: Snoop event (code 0x22). A valid response counts only if both of these unit-mask bits are set:
  - bit [type], where the response type is 3 bits with values 0..4;
  - bit [5+source], where the source is 2 bits with external snoop=0, core request=1, eviction=2.
- R7: Occupancy events. Code 0x80 adds the all-entries occupancy and code 0x83 adds the coherent-queue occupancy. Only counter 0 counts them; the same codes on any other counter add nothing.
- R8: A counter write takes effect at the next edge and wins over an increment in the same cycle. The counter resumes counting from the written value.
- R9: Counters are 48 bits wide and wrap silently modulo 2^48.
- R10: With the enable bit clear, the counter holds its value. Disabling also forgets the edge detector's previous condition, so the first true cycle after re-enabling counts.
- R11: After reset, every counter and every control word reads zero.
- R12: Control word layout:
  - event code in bits [7:0];
  - unit mask in bits [15:8];
  - threshold in bits [23:16];
  - edge detect in bit 24, invert in bit 25 and enable in bit 26.
  
  All other bits read back as zero. The address is {counter index, select}, with select 0 for the control word and select 1 for the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address {index, select} |
| wrData | input | 48 | Write data |
| rdAddr | input | 3 | Read address {index, select} |
| rdData | output | 48 | Combinational read data |
| lkValid | input | 4 | Per-slot lookup valid |
| lkState | input | 8 | Per-slot 2-bit line state |
| lkReq | input | 8 | Per-slot 2-bit request type |
| snValid | input | 2 | Per-slot snoop response valid |
| snType | input | 6 | Per-slot 3-bit response type |
| snSrc | input | 4 | Per-slot 2-bit snoop source |
| occAll | input | 5 | All-entries tracker occupancy |
| occCoh | input | 5 | Coherent-queue occupancy |

## Verification
The bench aims mostly at the edges of the qualifying pipeline:
- Event counts exactly at the threshold, and one below and one above it. An off-by-one comparison shifts the threshold and inverted totals by one.
- Lookups and snoops that match only one of the two mask groups. A design that ORs the groups counts them.
- An occupancy event programmed on a counter other than counter 0. A leak here shows up as a nonzero count.
- A counter write that lands together with an increment. A wrong priority returns the written value plus the increment.
- An increment just below the 48-bit limit, which must wrap to a small value.
- Re-enabling an edge counter while its condition stays true. If the stored condition survives the disable, that re-enable adds nothing.

// File: rtl/uec_pkg.sv
package uec_pkg;
  typedef struct packed {
    logic load;
    logic add;
  } ctrStrobe_t;

  localparam logic [7:0] EV_LOOKUP  = 8'h34;
  localparam logic [7:0] EV_SNOOP   = 8'h22;
  localparam logic [7:0] EV_OCC_ALL = 8'h80;
  localparam logic [7:0] EV_OCC_COH = 8'h83;

  localparam int BIT_EDGE = 24;
  localparam int BIT_INV  = 25;
  localparam int BIT_EN   = 26;
  localparam logic [31:0] CTRL_MASK = 32'h07FF_FFFF;
endpackage

// File: rtl/uec_ctl.sv
module uec_ctl
  import uec_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int LK_N    = 4,
  parameter int SN_N    = 2,
  parameter int OCC_W   = 5,
  parameter int RAW_W   = 5,
  parameter int AW      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [31:0]       wrCtrl,
  input  logic [LK_N-1:0]   lkValid,
  input  logic [2*LK_N-1:0] lkState,
  input  logic [2*LK_N-1:0] lkReq,
  input  logic [SN_N-1:0]   snValid,
  input  logic [3*SN_N-1:0] snType,
  input  logic [2*SN_N-1:0] snSrc,
  input  logic [OCC_W-1:0]  occAll,
  input  logic [OCC_W-1:0]  occCoh,
  output ctrStrobe_t        strobe [NUM_CTR],
  output logic [RAW_W-1:0]  amount [NUM_CTR],
  output logic [31:0]       ctrlOut [NUM_CTR]
);
  localparam int IDX_W = AW - 1;
  localparam int CMP_W = (RAW_W > 8) ? RAW_W : 8;

  for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
    logic [31:0]      ctrlQ;
    logic             prevQ;
    logic [7:0]       evt, umask, cmask;
    logic             edgeEn, invEn, enBit;
    logic [RAW_W-1:0] lkCnt, snCnt, raw;
    logic [CMP_W-1:0] rawX, cmX;
    logic             cond, pulse;

    assign evt    = ctrlQ[7:0];
    assign umask  = ctrlQ[15:8];
    assign cmask  = ctrlQ[23:16];
    assign edgeEn = ctrlQ[BIT_EDGE];
    assign invEn  = ctrlQ[BIT_INV];
    assign enBit  = ctrlQ[BIT_EN];

    // lookup qualification: state group AND request group
    always_comb begin
      lkCnt = '0;
      for (int k = 0; k < LK_N; k++) begin
        if (lkValid[k] && umask[{1'b0, lkState[2*k +: 2]}] &&
            umask[{1'b1, lkReq[2*k +: 2]}])
          lkCnt = lkCnt + RAW_W'(1);
      end
    end

    // snoop qualification: response type AND source
    always_comb begin
      snCnt = '0;
      for (int k = 0; k < SN_N; k++) begin
        if (snValid[k] && (snType[3*k +: 3] < 3'd5) && umask[snType[3*k +: 3]] &&
            (snSrc[2*k +: 2] != 2'd3) && umask[3'd5 + {1'b0, snSrc[2*k +: 2]}])
          snCnt = snCnt + RAW_W'(1);
      end
    end

    always_comb begin
      raw = '0;
      case (evt)
        EV_LOOKUP:  raw = lkCnt;
        EV_SNOOP:   raw = snCnt;
        EV_OCC_ALL: raw = (c == 0) ? RAW_W'(occAll) : '0;
        EV_OCC_COH: raw = (c == 0) ? RAW_W'(occCoh) : '0;
        default:    raw = '0;
      endcase
    end

    assign rawX  = CMP_W'(raw);
    assign cmX   = CMP_W'(cmask);
    assign cond  = (cmask != 8'd0) ? (invEn ? (rawX < cmX) : (rawX >= cmX))
                                   : (raw != '0);
    assign pulse = edgeEn ? (cond && !prevQ) : cond;

    always_comb begin
      if (cmask == 8'd0 && !edgeEn) amount[c] = raw;
      else                          amount[c] = RAW_W'(pulse);
    end

    assign strobe[c].add  = enBit && (amount[c] != '0);
    assign strobe[c].load = wrEn && (wrAddr == {IDX_W'(c), 1'b1});
    assign ctrlOut[c]     = ctrlQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrlQ <= '0;
        prevQ <= 1'b0;
      end else begin
        if (wrEn && wrAddr == {IDX_W'(c), 1'b0}) ctrlQ <= wrCtrl & CTRL_MASK;
        prevQ <= enBit ? cond : 1'b0;
      end
    end

    // R10: a disabled counter never receives an increment
    a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
      !enBit |-> !strobe[c].add);
    // R2: threshold or edge modes step by at most one
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rstN)
      (cmask != 8'd0 || edgeEn) |-> amount[c] <= RAW_W'(1));
    // R4: after an edge count, no count next cycle unless reprogrammed
    a_r4_edge_once: assert property (@(posedge clk) disable iff (!rstN)
      (enBit && edgeEn && strobe[c].add) |=> (!strobe[c].add || ctrlQ != $past(ctrlQ)));
    if (c != 0) begin : g_occ_chk
      // R7: occupancy codes never count outside counter 0
      a_r7_occ_ctr0: assert property (@(posedge clk) disable iff (!rstN)
        (evt == EV_OCC_ALL || evt == EV_OCC_COH) |-> !strobe[c].add);
    end
  end
endmodule

// File: rtl/uec_dp.sv
module uec_dp
  import uec_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 48,
  parameter int RAW_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrStrobe_t       strobe [NUM_CTR],
  input  logic [RAW_W-1:0] amount [NUM_CTR],
  input  logic [CTR_W-1:0] wrData,
  output logic [CTR_W-1:0] cnt [NUM_CTR]
);
  for (genvar c = 0; c < NUM_CTR; c++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN)                cnt[c] <= '0;
      else if (strobe[c].load)  cnt[c] <= wrData;
      else if (strobe[c].add)   cnt[c] <= cnt[c] + CTR_W'(amount[c]);
    end

    // R8: a write lands exactly, whatever the increment
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rstN)
      strobe[c].load |=> cnt[c] == $past(wrData));
    // R9: increments wrap modulo the counter width
    a_r9_wrap_add: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[c].add && !strobe[c].load) |=>
        cnt[c] == $past(cnt[c]) + CTR_W'($past(amount[c])));
    // R10: no strobe, no change
    a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe[c].add && !strobe[c].load) |=> $stable(cnt[c]));
  end
endmodule

// File: rtl/uec_top.sv
module uec_top
  import uec_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 48,
  parameter int LK_N    = 4,
  parameter int SN_N    = 2,
  parameter int OCC_W   = 5,
  localparam int AW     = $clog2(NUM_CTR) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [CTR_W-1:0]  wrData,
  input  logic [AW-1:0]     rdAddr,
  output logic [CTR_W-1:0]  rdData,
  input  logic [LK_N-1:0]   lkValid,
  input  logic [2*LK_N-1:0] lkState,
  input  logic [2*LK_N-1:0] lkReq,
  input  logic [SN_N-1:0]   snValid,
  input  logic [3*SN_N-1:0] snType,
  input  logic [2*SN_N-1:0] snSrc,
  input  logic [OCC_W-1:0]  occAll,
  input  logic [OCC_W-1:0]  occCoh
);
  localparam int LK_CW = $clog2(LK_N + 1);
  localparam int SN_CW = $clog2(SN_N + 1);
  localparam int RAW_A = (LK_CW > SN_CW) ? LK_CW : SN_CW;
  localparam int RAW_W = (OCC_W > RAW_A) ? OCC_W : RAW_A;

  ctrStrobe_t       strobe  [NUM_CTR];
  logic [RAW_W-1:0] amount  [NUM_CTR];
  logic [31:0]      ctrlOut [NUM_CTR];
  logic [CTR_W-1:0] cnt     [NUM_CTR];

  uec_ctl #(.NUM_CTR(NUM_CTR), .LK_N(LK_N), .SN_N(SN_N), .OCC_W(OCC_W),
            .RAW_W(RAW_W), .AW(AW)) i_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrCtrl(wrData[31:0]),
    .lkValid(lkValid), .lkState(lkState), .lkReq(lkReq),
    .snValid(snValid), .snType(snType), .snSrc(snSrc),
    .occAll(occAll), .occCoh(occCoh),
    .strobe(strobe), .amount(amount), .ctrlOut(ctrlOut));

  uec_dp #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .RAW_W(RAW_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .amount(amount),
    .wrData(wrData), .cnt(cnt));

  always_comb begin
    if (rdAddr[0]) rdData = cnt[rdAddr[AW-1:1]];
    else           rdData = CTR_W'(ctrlOut[rdAddr[AW-1:1]]);
  end
endmodule

// File: tb/test_uec_top.sv
module test_uec_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [47:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [47:0] rdData;
  logic [3:0]  lkValid = '0;
  logic [7:0]  lkState = '0, lkReq = '0;
  logic [1:0]  snValid = '0;
  logic [5:0]  snType = '0;
  logic [3:0]  snSrc = '0;
  logic [4:0]  occAll = '0, occCoh = '0;

  int nChecks = 0, nErr = 0;
  bit finished = 0;

  typedef struct {
    logic [2:0]  addr;
    logic [47:0] exp;
    string       tag;
  } item_t;
  item_t sbQ[$];

  uec_top i_uec_top (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [47:0] cw(input logic [7:0] ev, input logic [7:0] um,
      input logic [7:0] cm, input bit ed, input bit inv, input bit en);
    return {21'b0, en, inv, ed, cm, um, ev};
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input int idx, input bit sel, input logic [47:0] d);
    wrEn = 1'b1; wrAddr = {2'(idx), sel}; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic clearEv();
    lkValid = '0; lkState = '0; lkReq = '0;
    snValid = '0; snType = '0; snSrc = '0;
    occAll = '0; occCoh = '0;
  endtask

  task automatic setLk(input int k, input logic [1:0] st, input logic [1:0] rq);
    lkValid[k] = 1'b1; lkState[2*k +: 2] = st; lkReq[2*k +: 2] = rq;
  endtask

  task automatic setSn(input int k, input logic [2:0] ty, input logic [1:0] src);
    snValid[k] = 1'b1; snType[3*k +: 3] = ty; snSrc[2*k +: 2] = src;
  endtask

  // driver side of the scoreboard
  task automatic expectVal(input int idx, input bit sel, input logic [47:0] e, input string tag);
    item_t it;
    it.addr = {2'(idx), sel}; it.exp = e; it.tag = tag;
    sbQ.push_back(it);
    wait (sbQ.size() == 0);
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      wait (sbQ.size() != 0);
      rdAddr = sbQ[0].addr;
      #1;
      nChecks++;
      if (rdData !== sbQ[0].exp) begin
        nErr++;
        $display("FAIL %s: actual=%0h expected=%0h", sbQ[0].tag, rdData, sbQ[0].exp);
      end
      void'(sbQ.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    expectVal(1, 1, 48'd0, "R11 counter after reset");
    expectVal(1, 0, 48'd0, "R11 control after reset");

    // R5 lookups: M+read mask
    wr(0, 0, cw(8'h34, 8'h11, 8'd0, 0, 0, 1));
    wr(0, 1, 48'd0);
    setLk(0, 2'd0, 2'd0); setLk(1, 2'd0, 2'd1); setLk(2, 2'd1, 2'd0); setLk(3, 2'd0, 2'd0);
    tick(); clearEv();
    expectVal(0, 1, 48'd2, "R5 lookup M/read");
    // R5 lookups: S|I with write
    wr(0, 0, cw(8'h34, 8'h2C, 8'd0, 0, 0, 1));
    wr(0, 1, 48'd0);
    setLk(0, 2'd2, 2'd1); setLk(1, 2'd3, 2'd1); setLk(2, 2'd2, 2'd0); setLk(3, 2'd0, 2'd1);
    tick(); clearEv();
    expectVal(0, 1, 48'd2, "R5 lookup S|I/write");

    // R6 snoops
    wr(1, 0, cw(8'h22, 8'h21, 8'd0, 0, 0, 1));
    setSn(0, 3'd0, 2'd0); setSn(1, 3'd0, 2'd1);
    tick(); clearEv();
    expectVal(1, 1, 48'd1, "R6 snoop type0/ext");
    wr(1, 1, 48'd0);
    wr(1, 0, cw(8'h22, 8'hC6, 8'd0, 0, 0, 1));
    setSn(0, 3'd1, 2'd2); setSn(1, 3'd2, 2'd0);
    tick(); clearEv();
    expectVal(1, 1, 48'd1, "R6 snoop type1-2/core-evict");

    // R1 raw occupancy sum
    wr(0, 0, cw(8'h80, 8'h00, 8'd0, 0, 0, 1));
    wr(0, 1, 48'd0);
    occAll = 5'd13; tick(); tick(); clearEv();
    expectVal(0, 1, 48'd26, "R1 raw sum");

    // R7 occupancy on other counters ignored; 0x83 on counter 0
    wr(2, 0, cw(8'h80, 8'h00, 8'd0, 0, 0, 1));
    occAll = 5'd13; tick(); clearEv();
    expectVal(2, 1, 48'd0, "R7 occ on ctr2");
    wr(3, 0, cw(8'h83, 8'h00, 8'd0, 0, 0, 1));
    wr(0, 0, cw(8'h83, 8'h00, 8'd0, 0, 0, 1));
    wr(0, 1, 48'd0);
    occCoh = 5'd7; tick(); clearEv();
    expectVal(0, 1, 48'd7, "R7 coherent occ ctr0");
    expectVal(3, 1, 48'd0, "R7 coherent occ ctr3");

    // R2 threshold 10
    wr(0, 0, cw(8'h80, 8'h00, 8'd10, 0, 0, 1));
    wr(0, 1, 48'd0);
    occAll = 5'd9; tick(); occAll = 5'd10; tick(); occAll = 5'd12; tick(); clearEv();
    expectVal(0, 1, 48'd2, "R2 threshold");

    // R3 inverted threshold 10
    occAll = 5'd31;
    wr(0, 0, cw(8'h80, 8'h00, 8'd10, 0, 1, 1));
    wr(0, 1, 48'd0);
    occAll = 5'd9; tick(); occAll = 5'd10; tick(); occAll = 5'd12; tick();
    occAll = 5'd31;
    wr(0, 0, cw(8'h80, 8'h00, 8'd10, 0, 1, 0));
    clearEv();
    expectVal(0, 1, 48'd1, "R3 inverted threshold");

    // R4 edge detect, threshold 5
    wr(0, 0, cw(8'h80, 8'h00, 8'd5, 1, 0, 1));
    wr(0, 1, 48'd0);
    occAll = 5'd6; tick(); occAll = 5'd7; tick(); occAll = 5'd0; tick();
    occAll = 5'd8; tick(); tick();
    expectVal(0, 1, 48'd2, "R4 edge detect");

    // R10 freeze and edge memory cleared on disable (condition held true)
    wr(0, 0, cw(8'h80, 8'h00, 8'd5, 1, 0, 0));
    tick(); tick();
    expectVal(0, 1, 48'd2, "R10 frozen while disabled");
    wr(0, 0, cw(8'h80, 8'h00, 8'd5, 1, 0, 1));
    tick();
    expectVal(0, 1, 48'd3, "R10 re-enable counts first true cycle");
    clearEv();

    // R8 write beats increment, then resumes
    wr(0, 0, cw(8'h80, 8'h00, 8'd0, 0, 0, 1));
    occAll = 5'd5;
    wr(0, 1, 48'd100);
    expectVal(0, 1, 48'd100, "R8 write priority");
    tick(); clearEv();
    expectVal(0, 1, 48'd105, "R8 resume after write");

    // R9 wrap
    wr(0, 1, 48'hFFFF_FFFF_FFFE);
    occAll = 5'd5; tick(); clearEv();
    expectVal(0, 1, 48'd3, "R9 wrap");

    // R12 layout and masked bits
    expectVal(3, 0, cw(8'h83, 8'h00, 8'd0, 0, 0, 1), "R12 control readback");
    wr(3, 0, 48'hFFFF_FFFF_FFFF);
    expectVal(3, 0, 48'h0000_07FF_FFFF, "R12 undefined bits zero");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule